// File: doc/BRIEF.md
# Nonvolatile Store Handshake Controller

This controller sits beside an SRAM whose contents are mirrored into nonvolatile shadow cells. It decides when a save into those cells may begin, and it keeps the memory port quiet while the save runs. A shared busy/request wire, which a pull-up holds high, connects it to the outside world. Any agent may pull that wire low to ask for a save. The controller pulls it low itself for as long as a save is running. A software or automatic trigger pulse asks for a save through the same sequence.

Once asked, the controller opens a drain window of a fixed number of cycles. During the window reads are still served, so that memory cycles already under way can finish, but new writes are turned away. When the window closes, it looks at a flag that records whether any write has been accepted since the last save or restore. If the flag is set, it starts the store engine and pulls the wire low until the engine reports done. If the flag is clear, no save is made. When the request came from the wire, the memory then stays closed until the wire is seen high again.

Top module: `nvs_store_ctrl`

## Requirements
- R1: After reset `line_pull` and `store_start` are 0, and in the idle phase `rd_gnt` follows `rd_req` and `wr_gnt` follows `wr_req`.
- R2: A high-to-low change of `line_in`, seen after `SYNC_STAGES` synchronizer flops, or a one-cycle `sw_trig` pulse in the idle phase opens a drain window that lasts exactly `DRAIN_CYCLES` clock cycles.
- R3: During the drain window reads are granted (`rd_gnt` = `rd_req`) and every write is refused (`wr_gnt` = 0).
- R4: When the window ends with the written-since-save flag set, `store_start` pulses high for exactly one cycle. `line_pull` is 1 from that cycle until the cycle in which `store_done` arrives.
- R5: When the window ends with the flag clear, no `store_start` pulse occurs and `line_pull` stays 0.
- R6: A granted write sets the flag. `store_done` during a save clears it, and so does a `recall_done` pulse. If a write is granted in the same cycle as `recall_done`, the flag ends up set.
- R7: While a save runs, no reads or writes are granted. After `store_done`, nothing is granted until the synchronized wire reads high.
- R8: After a skipped save, the controller waits for the synchronized wire to read high when it is low at the end of the window. When the wire is already high, as in a skipped software trigger, it returns straight to the idle phase.
- R9: `sw_trig` and falling edges of the wire are ignored outside the idle phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Sensed level of the shared busy/request wire (asynchronous) |
| line_pull | output | 1 | Pull-down enable for the shared wire; 1 drives it low |
| rd_req | input | 1 | SRAM read request |
| rd_gnt | output | 1 | SRAM read grant |
| wr_req | input | 1 | SRAM write request |
| wr_gnt | output | 1 | SRAM write grant |
| sw_trig | input | 1 | Software or automatic save trigger pulse |
| recall_done | input | 1 | Pulse marking the end of a restore from shadow cells |
| store_start | output | 1 | One-cycle pulse that starts the store engine |
| store_done | input | 1 | Store engine completion pulse |

## Verification
The bench builds the controller with `DRAIN_CYCLES` = 4 and `SYNC_STAGES` = 2. With a window that short, every cycle of the read-only drain phase can be counted one by one, and many save, skip and lock episodes fit in a short run. These include a write and a restore landing in the same cycle, software triggers with the wire high, and triggers that arrive while the memory is locked. With two synchronizer stages, the three-cycle lag from the wire to the controller reacting is short enough to place the lock and release checks on exact cycles.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_STORE = 2'd2,
        ST_LOCK  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic rd_ok;
        logic wr_ok;
        logic pull;
    } access_t;

    // Which memory accesses each phase admits, and whether the wire is pulled.
    function automatic access_t access_of(seq_state_e s);
        access_t a;
        a.rd_ok = (s == ST_IDLE) || (s == ST_DRAIN);
        a.wr_ok = (s == ST_IDLE);
        a.pull  = (s == ST_STORE);
        return a;
    endfunction

    // Phase entered when the drain window closes.
    function automatic seq_state_e drain_exit(logic dirty, logic line_hi);
        if (dirty)
            return ST_STORE;
        else if (line_hi)
            return ST_IDLE;
        else
            return ST_LOCK;
    endfunction

endpackage

// File: rtl/nvs_line_sync.sv
module nvs_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic line_hi,
    output logic line_fall
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    generate
        for (genvar i = 0; i < CHAIN; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b1;
                    else     chain_q[i] <= line_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b1;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign line_hi   = chain_q[SYNC_STAGES-1];
    assign line_fall = chain_q[SYNC_STAGES] & ~chain_q[SYNC_STAGES-1];
endmodule

// File: rtl/nvs_drain_timer.sv
module nvs_drain_timer #(
    parameter int DRAIN_CYCLES = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int CW = (DRAIN_CYCLES > 1) ? $clog2(DRAIN_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(DRAIN_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= LOAD_VAL;
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/nvs_dirty_track.sv
module nvs_dirty_track (
    input  logic clk,
    input  logic rst,
    input  logic mark,
    input  logic clear,
    output logic dirty
);
    logic dirty_q;

    always_ff @(posedge clk) begin
        if (rst)
            dirty_q <= 1'b0;
        else if (mark)
            dirty_q <= 1'b1;
        else if (clear)
            dirty_q <= 1'b0;
    end

    assign dirty = dirty_q;
endmodule

// File: rtl/nvs_seq_fsm.sv
module nvs_seq_fsm
    import nvs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       line_fall,
    input  logic       line_hi,
    input  logic       sw_trig,
    input  logic       drain_expired,
    input  logic       dirty,
    input  logic       store_done,
    output seq_state_e state,
    output logic       timer_load,
    output logic       timer_run,
    output logic       store_start,
    output logic       store_finish
);
    seq_state_e state_q, state_d;
    logic       start_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (line_fall || sw_trig) state_d = ST_DRAIN;
            ST_DRAIN: if (drain_expired) state_d = drain_exit(dirty, line_hi);
            ST_STORE: if (store_done) state_d = ST_LOCK;
            ST_LOCK:  if (line_hi) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            start_q <= (state_q == ST_DRAIN) && (state_d == ST_STORE);
        end
    end

    assign state        = state_q;
    assign timer_load   = (state_q == ST_IDLE) && (line_fall || sw_trig);
    assign timer_run    = (state_q == ST_DRAIN);
    assign store_start  = start_q;
    assign store_finish = (state_q == ST_STORE) && store_done;
endmodule

// File: rtl/nvs_store_ctrl.sv
module nvs_store_ctrl
    import nvs_pkg::*;
#(
    parameter int DRAIN_CYCLES = 32,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic line_pull,
    input  logic rd_req,
    output logic rd_gnt,
    input  logic wr_req,
    output logic wr_gnt,
    input  logic sw_trig,
    input  logic recall_done,
    output logic store_start,
    input  logic store_done
);
    logic       line_hi, line_fall;
    logic       drain_expired, dirty_q;
    logic       timer_load, timer_run, store_finish;
    seq_state_e state;
    access_t    acc;

    nvs_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .line_in   (line_in),
        .line_hi   (line_hi),
        .line_fall (line_fall)
    );

    nvs_drain_timer #(.DRAIN_CYCLES(DRAIN_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (timer_load),
        .run     (timer_run),
        .expired (drain_expired)
    );

    nvs_seq_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .line_fall     (line_fall),
        .line_hi       (line_hi),
        .sw_trig       (sw_trig),
        .drain_expired (drain_expired),
        .dirty         (dirty_q),
        .store_done    (store_done),
        .state         (state),
        .timer_load    (timer_load),
        .timer_run     (timer_run),
        .store_start   (store_start),
        .store_finish  (store_finish)
    );

    assign acc       = access_of(state);
    assign rd_gnt    = rd_req & acc.rd_ok;
    assign wr_gnt    = wr_req & acc.wr_ok;
    assign line_pull = acc.pull;

    nvs_dirty_track u_dirty (
        .clk   (clk),
        .rst   (rst),
        .mark  (wr_gnt),
        .clear (store_finish | recall_done),
        .dirty (dirty_q)
    );
endmodule

// File: rtl/nvs_store_ctrl_chk.sv
module nvs_store_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic rd_gnt,
    input logic wr_gnt,
    input logic line_pull,
    input logic store_start,
    input logic store_done,
    input logic dirty
);
    // R7
    pull_blocks_access_chk: assert property (@(posedge clk) disable iff (rst)
        line_pull |-> (!rd_gnt && !wr_gnt));

    // R4
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        store_start |=> !store_start);

    // R4
    start_with_pull_chk: assert property (@(posedge clk) disable iff (rst)
        store_start |-> line_pull);

    // R4
    pull_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (line_pull && !store_done) |=> line_pull);

    // R5
    start_needs_dirty_chk: assert property (@(posedge clk) disable iff (rst)
        store_start |-> dirty);

    // R6
    write_marks_dirty_chk: assert property (@(posedge clk) disable iff (rst)
        wr_gnt |=> dirty);
endmodule

bind nvs_store_ctrl nvs_store_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_gnt      (rd_gnt),
    .wr_gnt      (wr_gnt),
    .line_pull   (line_pull),
    .store_start (store_start),
    .store_done  (store_done),
    .dirty       (dirty_q)
);

// File: tb/sim_nvs_store_ctrl.sv
module sim_nvs_store_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DC = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext_low = 1'b0;
    logic rd_req = 1'b0, wr_req = 1'b0, sw_trig = 1'b0;
    logic recall_done = 1'b0, store_done = 1'b0;
    logic line_pull, rd_gnt, wr_gnt, store_start;
    logic line_in;

    assign line_in = !(ext_low || line_pull);

    always #(CLK_PERIOD/2) clk = ~clk;

    nvs_store_ctrl #(.DRAIN_CYCLES(DC), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .line_in(line_in), .line_pull(line_pull),
        .rd_req(rd_req), .rd_gnt(rd_gnt), .wr_req(wr_req), .wr_gnt(wr_gnt),
        .sw_trig(sw_trig), .recall_done(recall_done),
        .store_start(store_start), .store_done(store_done)
    );

    int checks = 0, fails = 0;
    bit finished = 0;

    typedef struct {
        int    starts;
        bit    pulled;
        string req;
    } episode_t;

    episode_t exp_q[$];
    int  seen_starts = 0;
    int  seen_pull = 0;
    bit  close_req = 0;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    // Driver side of the scoreboard: expected outcome of an episode.
    task automatic expect_episode(input int starts, input bit pulled, input string req);
        episode_t e;
        e.starts = starts; e.pulled = pulled; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic close_episode();
        close_req = 1;
        wait (close_req == 0);
        #1;
    endtask

    // Monitor: accumulates observed events and compares at episode close.
    initial begin
        forever begin
            @(negedge clk);
            if (close_req) begin
                episode_t e;
                if (exp_q.size() == 0) begin
                    check("scoreboard_empty", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check({e.req, " store_start count"}, seen_starts, e.starts);
                    check({e.req, " line_pull seen"}, int'(seen_pull > 0), int'(e.pulled));
                end
                seen_starts = 0;
                seen_pull = 0;
                close_req = 0;
            end
            if (!rst && store_start) seen_starts++;
            if (!rst && line_pull) seen_pull++;
        end
    end

    // Store engine model: completes three cycles after the start pulse.
    initial begin
        forever begin
            @(negedge clk);
            if (store_start) begin
                repeat (3) @(negedge clk);
                store_done = 1'b1;
                @(negedge clk);
                store_done = 1'b0;
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int n;
        step(3);
        rst = 1'b0;
        step(1);

        // R1: reset state and idle grants
        check("R1 line_pull after reset", line_pull, 0);
        check("R1 store_start after reset", store_start, 0);
        rd_req = 1; wr_req = 0; #1;
        check("R1 idle read grant", rd_gnt, 1);

        // R5/R8: clean wire request is skipped and locks until release
        expect_episode(0, 0, "R5 clean wire request");
        ext_low = 1;
        step(3 + DC + 2);
        check("R8 locked after skip while wire low", rd_gnt, 0);
        // R9: software trigger ignored while locked
        sw_trig = 1; step(1); sw_trig = 0;
        ext_low = 0;
        step(5);
        wr_req = 1; #1;
        check("R9 idle write grant, no drain after ignored trigger", wr_gnt, 1);
        step(1); wr_req = 0;
        recall_done = 1; step(1); recall_done = 0;
        close_episode();

        // R2/R3/R4: dirty wire request, drain length and save
        wr_req = 1; #1;
        check("R1 idle write grant", wr_gnt, 1);
        step(1);
        expect_episode(1, 1, "R4 dirty wire request");
        ext_low = 1;
        n = 0;
        for (int i = 0; i < 40; i++) begin
            step(1);
            if (!rd_gnt) break;
            if (!wr_gnt) n++;
        end
        wr_req = 0;
        check("R2 R3 drain cycles with reads only", n, DC);
        check("R4 line_pull while saving", line_pull, 1);
        check("R7 no read grant while saving", rd_gnt, 0);
        for (int i = 0; i < 20 && line_pull; i++) step(1);
        check("R4 line_pull released after done", line_pull, 0);
        step(2);
        check("R7 locked after save while wire low", rd_gnt, 0);
        ext_low = 0;
        step(5);
        check("R7 reads back after release", rd_gnt, 1);
        close_episode();

        // R6: save cleared the flag, next request is skipped
        expect_episode(0, 0, "R6 flag cleared by save");
        ext_low = 1; step(3 + DC + 2); ext_low = 0; step(5);
        close_episode();

        // R6: recall clears the flag
        wr_req = 1; step(1); wr_req = 0;
        recall_done = 1; step(1); recall_done = 0;
        expect_episode(0, 0, "R6 recall clears flag");
        ext_low = 1; step(3 + DC + 2); ext_low = 0; step(5);
        close_episode();

        // R6: write and recall in the same cycle, write wins
        wr_req = 1; recall_done = 1; #1;
        check("R6 write granted alongside recall", wr_gnt, 1);
        step(1); wr_req = 0; recall_done = 0;
        expect_episode(1, 1, "R6 write beats recall");
        ext_low = 1; step(3 + DC + 12); ext_low = 0; step(5);
        close_episode();

        // R8: clean software trigger with wire high returns to idle directly
        expect_episode(0, 0, "R8 clean software trigger");
        sw_trig = 1; step(1); sw_trig = 0;
        wr_req = 1; #1;
        n = 0;
        for (int i = 0; i < 40; i++) begin
            if (wr_gnt) break;
            if (rd_gnt) n++;
            step(1);
        end
        check("R2 R8 software drain then write grant", n, DC);
        check("R8 write granted after skip", wr_gnt, 1);
        step(1); wr_req = 0;
        close_episode();

        // R4/R7: dirty software trigger saves and reopens without wire action
        expect_episode(1, 1, "R4 dirty software trigger");
        sw_trig = 1; step(1); sw_trig = 0;
        step(DC + 1);
        check("R4 software save pulls wire", line_pull, 1);
        for (int i = 0; i < 20 && line_pull; i++) step(1);
        step(5);
        check("R7 software save reopens after wire high", rd_gnt, 1);
        close_episode();

        finish_run();
    end
endmodule